// File: doc/BRIEF.md
# Bufferless Deflection Mesh Router

This block is one node of a two-dimensional mesh network. It has four mesh links (north, east, south, west) and a local port toward the attached processing element. It holds no input queues. Every flit that arrives on a mesh link in a cycle is assigned an output in that same cycle and sits only in the output register stage. It then leaves on a mesh link, or on the ejection port when it has reached this node.

Routing is dimension-ordered. The X coordinate is corrected first, then Y. When two flits want the same link, the one with the larger age field wins it. The loser goes to its other productive link if there is one and it is free, otherwise to any free link. Flits are never dropped or held back. The local element may inject a new flit only in a cycle where the transit traffic leaves a mesh link unused. Links that point off the edge of the mesh are never driven.

Top module: `defl_router`

## Requirements
- R1: While rst_ni is low, every mesh output and the ejection output are invalid, with all fields zero.
- R2: Every valid flit on a connected mesh input leaves exactly once on the next clock edge, on one mesh output or on the ejection port, with destination and payload unchanged. Flit layout, MSB to LSB: valid (1), destination X (3), destination Y (3), age (4), payload (32). Port index order is north=0, east=1, south=2, west=3.
- R3: A flit whose destination equals my_x_i/my_y_i is ejected when the ejection port is still free. At most one flit is ejected per cycle, and further local flits are deflected onto free mesh links.
- R4: When it has its first choice, a flit with a differing X leaves east (destination X greater) or west (destination X smaller). With X equal, it leaves north (destination Y greater) or south (destination Y smaller).
- R5: Flits are served in order of larger age first, with equal ages served in port order north, east, south, west. A flit whose first productive link is taken uses its second productive link if it has one and it is free. Otherwise it uses the first free connected link in port order north, east, south, west.
- R6: A transit flit leaves with its age incremented by one, saturating at 15. An injected flit leaves with age 0.
- R7: inj_ready_o is high in the same cycle exactly when fewer than the number of connected links are claimed by valid mesh inputs that were not ejected. A request made while it is low produces no output.
- R8: A link with no neighbour (north at Y=7, south at Y=0, east at X=7, west at X=0) never carries a valid flit.
- R9: An accepted injected flit is served after all transit flits, under the rules of R3, R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| my_x_i | input | 3 | X coordinate of this node |
| my_y_i | input | 3 | Y coordinate of this node |
| in_flit_i | input | 4x43 | Incoming flits, index 0..3 = N, E, S, W |
| inj_vld_i | input | 1 | Local injection request |
| inj_dx_i | input | 3 | Destination X of injected flit |
| inj_dy_i | input | 3 | Destination Y of injected flit |
| inj_data_i | input | 32 | Payload of injected flit |
| inj_ready_o | output | 1 | A mesh link is free for injection this cycle |
| out_flit_o | output | 4x43 | Registered outgoing flits, index 0..3 = N, E, S, W |
| ej_vld_o | output | 1 | Ejected flit valid |
| ej_data_o | output | 32 | Ejected payload |

## Verification
inj_ready_o is combinational and is due in the same cycle as the mesh inputs and the injection request. All flit results, on the mesh outputs and on the ejection port, are due after the one register stage, at the next rising edge. The bench applies each stimulus at a falling edge and checks inj_ready_o one nanosecond later against its own model of that cycle. It then waits through one rising edge and compares every output with the model's prediction at the following falling edge, before the next stimulus is driven.

// File: rtl/defl_router_pkg.sv
package defl_router_pkg;
  localparam int X_W    = 3;
  localparam int Y_W    = 3;
  localparam int AGE_W  = 4;
  localparam int DATA_W = 32;
  localparam int NPORT  = 4;
  localparam int RANK_W = $clog2(NPORT);
  localparam int CNT_W  = $clog2(NPORT + 2);

  // mesh port indices; order is also the tie-break order
  localparam logic [1:0] P_N = 2'd0;
  localparam logic [1:0] P_E = 2'd1;
  localparam logic [1:0] P_S = 2'd2;
  localparam logic [1:0] P_W = 2'd3;

  // output selector: 0..3 mesh port, 4 eject, 7 none
  localparam logic [2:0] D_EJ   = 3'd4;
  localparam logic [2:0] D_NONE = 3'd7;

  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  typedef struct packed {
    logic              vld;
    logic [X_W-1:0]    dx;
    logic [Y_W-1:0]    dy;
    logic [AGE_W-1:0]  age;
    logic [DATA_W-1:0] data;
  } flit_t;

  localparam int FLIT_W = $bits(flit_t);
endpackage

// File: rtl/defl_route_calc.sv
module defl_route_calc
  import defl_router_pkg::*;
(
  input  logic           vld_i,
  input  logic [X_W-1:0] dx_i,
  input  logic [Y_W-1:0] dy_i,
  input  logic [X_W-1:0] my_x_i,
  input  logic [Y_W-1:0] my_y_i,
  output logic           here_o,
  output logic [1:0]     first_o,
  output logic           first_vld_o,
  output logic [1:0]     second_o,
  output logic           second_vld_o
);
  logic x_pos, x_neg, y_pos, y_neg;

  always_comb begin
    x_pos  = dx_i > my_x_i;
    x_neg  = dx_i < my_x_i;
    y_pos  = dy_i > my_y_i;
    y_neg  = dy_i < my_y_i;
    here_o = vld_i & ~(x_pos | x_neg | y_pos | y_neg);
    if (x_pos | x_neg) begin
      first_o      = x_pos ? P_E : P_W;
      first_vld_o  = vld_i;
      second_o     = y_pos ? P_N : P_S;
      second_vld_o = vld_i & (y_pos | y_neg);
    end else begin
      first_o      = y_pos ? P_N : P_S;
      first_vld_o  = vld_i & (y_pos | y_neg);
      second_o     = P_N;
      second_vld_o = 1'b0;
    end
  end
endmodule

// File: rtl/defl_rank.sv
module defl_rank
  import defl_router_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NPORT-1:0]               vld_i,
  input  logic [NPORT-1:0][AGE_W-1:0]    age_i,
  output logic [NPORT-1:0][RANK_W-1:0]   rank_o
);
  logic [RANK_W:0] cnt;

  // rank = number of valid flits that beat this one
  always_comb begin
    cnt    = '0;
    rank_o = '0;
    for (int i = 0; i < NPORT; i++) begin
      cnt = '0;
      for (int j = 0; j < NPORT; j++) begin
        if (j != i && vld_i[j] &&
            ((age_i[j] > age_i[i]) || (age_i[j] == age_i[i] && j < i)))
          cnt = cnt + 1'b1;
      end
      rank_o[i] = cnt[RANK_W-1:0];
    end
  end

  logic [NPORT-1:0] hit [NPORT];
  always_comb begin
    for (int r = 0; r < NPORT; r++)
      for (int i = 0; i < NPORT; i++)
        hit[r][i] = vld_i[i] && (rank_o[i] == RANK_W'(r));
  end

  for (genvar r = 0; r < NPORT; r++) begin : g_rank_chk
    assert_rank_unique_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(hit[r]));
  end
endmodule

// File: rtl/defl_alloc.sv
module defl_alloc
  import defl_router_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NPORT-1:0]             exist_i,
  input  logic [NPORT-1:0]             vld_i,
  input  logic [NPORT-1:0][RANK_W-1:0] rank_i,
  input  logic [NPORT-1:0]             here_i,
  input  logic [NPORT-1:0][1:0]        first_i,
  input  logic [NPORT-1:0]             first_vld_i,
  input  logic [NPORT-1:0][1:0]        second_i,
  input  logic [NPORT-1:0]             second_vld_i,
  input  logic                         inj_vld_i,
  input  logic                         inj_here_i,
  input  logic [1:0]                   inj_first_i,
  input  logic                         inj_first_vld_i,
  input  logic [1:0]                   inj_second_i,
  input  logic                         inj_second_vld_i,
  output logic [NPORT-1:0][2:0]        sel_o,
  output logic                         inj_ready_o,
  output logic                         inj_take_o,
  output logic [2:0]                   inj_sel_o
);
  function automatic logic [2:0] pick(input logic here, input logic [1:0] f,
                                      input logic fv, input logic [1:0] s,
                                      input logic sv, input logic [NPORT-1:0] free,
                                      input logic ej_free);
    logic [2:0] d;
    d = D_NONE;
    if (here && ej_free)            d = D_EJ;
    else if (fv && free[f])         d = {1'b0, f};
    else if (sv && free[s])         d = {1'b0, s};
    else begin
      for (int k = NPORT - 1; k >= 0; k--)
        if (free[k]) d = 3'(k);
    end
    return d;
  endfunction

  logic [NPORT-1:0] free;
  logic             ej_free;
  logic [2:0]       d;

  always_comb begin
    free      = exist_i;
    ej_free   = 1'b1;
    d         = D_NONE;
    sel_o     = {NPORT{D_NONE}};
    for (int r = 0; r < NPORT; r++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (vld_i[i] && rank_i[i] == RANK_W'(r)) begin
          d = pick(here_i[i], first_i[i], first_vld_i[i], second_i[i],
                   second_vld_i[i], free, ej_free);
          sel_o[i] = d;
          if (d == D_EJ)        ej_free = 1'b0;
          else if (d != D_NONE) free[d[1:0]] = 1'b0;
        end
      end
    end
    inj_ready_o = |free;
    inj_take_o  = inj_vld_i & inj_ready_o;
    inj_sel_o   = D_NONE;
    if (inj_take_o)
      inj_sel_o = pick(inj_here_i, inj_first_i, inj_first_vld_i, inj_second_i,
                       inj_second_vld_i, free, ej_free);
  end

  // claim[o] collects every requester granted output o (row NPORT = eject)
  logic [NPORT:0] claim [NPORT+1];
  always_comb begin
    for (int o = 0; o <= NPORT; o++) begin
      for (int i = 0; i < NPORT; i++)
        claim[o][i] = vld_i[i] && (sel_o[i] == 3'(o));
      claim[o][NPORT] = inj_take_o && (inj_sel_o == 3'(o));
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_claim_chk
    assert_one_claim_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(claim[o]));
  end

  assert_single_eject_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim[NPORT]));

  for (genvar i = 0; i < NPORT; i++) begin : g_orphan_chk
    assert_no_orphan_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_i[i] |-> sel_o[i] != D_NONE);
  end
endmodule

// File: rtl/defl_router.sv
module defl_router
  import defl_router_pkg::*;
#(
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [X_W-1:0]                my_x_i,
  input  logic [Y_W-1:0]                my_y_i,
  input  logic [NPORT-1:0][FLIT_W-1:0]  in_flit_i,
  input  logic                          inj_vld_i,
  input  logic [X_W-1:0]                inj_dx_i,
  input  logic [Y_W-1:0]                inj_dy_i,
  input  logic [DATA_W-1:0]             inj_data_i,
  output logic                          inj_ready_o,
  output logic [NPORT-1:0][FLIT_W-1:0]  out_flit_o,
  output logic                          ej_vld_o,
  output logic [DATA_W-1:0]             ej_data_o
);
  localparam logic [X_W-1:0] X_MAX = X_W'(MESH_X - 1);
  localparam logic [Y_W-1:0] Y_MAX = Y_W'(MESH_Y - 1);

  flit_t                        in_f [NPORT];
  logic [NPORT-1:0]             exist, vld_g, here, first_vld, second_vld;
  logic [NPORT-1:0][1:0]        first, second;
  logic [NPORT-1:0][AGE_W-1:0]  age;
  logic [NPORT-1:0][RANK_W-1:0] rank;
  logic [NPORT-1:0][2:0]        sel;
  logic                         inj_here, inj_first_vld, inj_second_vld, inj_take;
  logic [1:0]                   inj_first, inj_second;
  logic [2:0]                   inj_sel;

  always_comb begin
    exist[P_N] = my_y_i != Y_MAX;
    exist[P_S] = my_y_i != '0;
    exist[P_E] = my_x_i != X_MAX;
    exist[P_W] = my_x_i != '0;
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_in
    assign in_f[g]  = flit_t'(in_flit_i[g]);
    assign vld_g[g] = in_f[g].vld & exist[g];
    assign age[g]   = in_f[g].age;

    defl_route_calc u_rc (
      .vld_i       (vld_g[g]),
      .dx_i        (in_f[g].dx),
      .dy_i        (in_f[g].dy),
      .my_x_i      (my_x_i),
      .my_y_i      (my_y_i),
      .here_o      (here[g]),
      .first_o     (first[g]),
      .first_vld_o (first_vld[g]),
      .second_o    (second[g]),
      .second_vld_o(second_vld[g])
    );
  end

  defl_route_calc u_rc_inj (
    .vld_i       (inj_vld_i),
    .dx_i        (inj_dx_i),
    .dy_i        (inj_dy_i),
    .my_x_i      (my_x_i),
    .my_y_i      (my_y_i),
    .here_o      (inj_here),
    .first_o     (inj_first),
    .first_vld_o (inj_first_vld),
    .second_o    (inj_second),
    .second_vld_o(inj_second_vld)
  );

  defl_rank u_rank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (vld_g),
    .age_i (age),
    .rank_o(rank)
  );

  defl_alloc u_alloc (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .exist_i         (exist),
    .vld_i           (vld_g),
    .rank_i          (rank),
    .here_i          (here),
    .first_i         (first),
    .first_vld_i     (first_vld),
    .second_i        (second),
    .second_vld_i    (second_vld),
    .inj_vld_i       (inj_vld_i),
    .inj_here_i      (inj_here),
    .inj_first_i     (inj_first),
    .inj_first_vld_i (inj_first_vld),
    .inj_second_i    (inj_second),
    .inj_second_vld_i(inj_second_vld),
    .sel_o           (sel),
    .inj_ready_o     (inj_ready_o),
    .inj_take_o      (inj_take),
    .inj_sel_o       (inj_sel)
  );

  flit_t             out_d [NPORT];
  flit_t             out_q [NPORT];
  flit_t             f;
  logic              ej_v_d;
  logic [DATA_W-1:0] ej_data_d;

  always_comb begin
    for (int o = 0; o < NPORT; o++) out_d[o] = '0;
    ej_v_d    = 1'b0;
    ej_data_d = '0;
    f         = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (vld_g[i] && sel[i] != D_NONE) begin
        f     = in_f[i];
        f.vld = 1'b1;
        f.age = (f.age == AGE_MAX) ? f.age : f.age + 1'b1;
        if (sel[i] == D_EJ) begin
          ej_v_d    = 1'b1;
          ej_data_d = f.data;
        end else begin
          out_d[sel[i][1:0]] = f;
        end
      end
    end
    if (inj_take && inj_sel != D_NONE) begin
      f = '{vld: 1'b1, dx: inj_dx_i, dy: inj_dy_i, age: '0, data: inj_data_i};
      if (inj_sel == D_EJ) begin
        ej_v_d    = 1'b1;
        ej_data_d = inj_data_i;
      end else begin
        out_d[inj_sel[1:0]] = f;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int o = 0; o < NPORT; o++) out_q[o] <= '0;
      ej_vld_o  <= 1'b0;
      ej_data_o <= '0;
    end else begin
      for (int o = 0; o < NPORT; o++) out_q[o] <= out_d[o];
      ej_vld_o  <= ej_v_d;
      ej_data_o <= ej_data_d;
    end
  end

  logic [NPORT-1:0] out_v;
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    assign out_flit_o[o] = out_q[o];
    assign out_v[o]      = out_q[o].vld;
  end

  logic [CNT_W-1:0] in_cnt, out_cnt;
  always_comb begin
    in_cnt  = CNT_W'($countones(vld_g)) + CNT_W'(inj_take);
    out_cnt = CNT_W'($countones(out_v)) + CNT_W'(ej_vld_o);
  end

  assert_no_loss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> out_cnt == $past(in_cnt));

  assert_edge_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (out_v & ~$past(exist)) == '0);
endmodule

// File: tb/defl_router_tb.sv
`timescale 1ns/1ps
module defl_router_tb;
  import defl_router_pkg::*;

  logic                         clk = 1'b0;
  logic                         rst_ni = 1'b0;
  logic [X_W-1:0]               my_x = '0;
  logic [Y_W-1:0]               my_y = '0;
  logic [NPORT-1:0][FLIT_W-1:0] in_flit = '0;
  logic                         inj_vld = 1'b0;
  logic [X_W-1:0]               inj_dx = '0;
  logic [Y_W-1:0]               inj_dy = '0;
  logic [DATA_W-1:0]            inj_data = '0;
  logic                         inj_ready;
  logic [NPORT-1:0][FLIT_W-1:0] out_flit;
  logic                         ej_vld;
  logic [DATA_W-1:0]            ej_data;

  always #2 clk = ~clk;

  defl_router u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .my_x_i(my_x), .my_y_i(my_y),
    .in_flit_i(in_flit), .inj_vld_i(inj_vld), .inj_dx_i(inj_dx),
    .inj_dy_i(inj_dy), .inj_data_i(inj_data), .inj_ready_o(inj_ready),
    .out_flit_o(out_flit), .ej_vld_o(ej_vld), .ej_data_o(ej_data)
  );

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  // stimulus
  int iv [4], ix [4], iy [4], ia [4];
  logic [31:0] idat [4];
  int jv, jx, jy;
  logic [31:0] jd;
  int mx, my;
  // expectation
  logic [FLIT_W-1:0] eo [4];
  int e_ej_v, e_rdy;
  logic [31:0] e_ej_d;
  bit m_fr [4];
  bit m_ejf;

  function automatic logic [FLIT_W-1:0] mk(int v, int x, int y, int a, logic [31:0] d);
    return {1'(v), 3'(x), 3'(y), 4'(a), d};
  endfunction

  function automatic bit has(int p);
    case (p)
      0: return my < 7;
      1: return mx < 7;
      2: return my > 0;
      default: return mx > 0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // route one flit by the spec; returns 0..3 mesh port, 4 eject
  task automatic place(input int dx, input int dy, output int d);
    int fp, sp;
    fp = -1; sp = -1; d = -1;
    if (dx > mx) fp = 1; else if (dx < mx) fp = 3;
    if (fp >= 0) begin
      if (dy > my) sp = 0; else if (dy < my) sp = 2;
    end else begin
      if (dy > my) fp = 0; else if (dy < my) fp = 2;
    end
    if (dx == mx && dy == my && m_ejf) d = 4;
    else if (fp >= 0 && m_fr[fp]) d = fp;
    else if (sp >= 0 && m_fr[sp]) d = sp;
    else for (int k = 3; k >= 0; k--) if (m_fr[k]) d = k;
    if (d == 4) m_ejf = 1'b0;
    else if (d >= 0) m_fr[d] = 1'b0;
  endtask

  task automatic model();
    bit done [4];
    int best, d, na;
    for (int p = 0; p < 4; p++) begin
      m_fr[p] = has(p); done[p] = 1'b0; eo[p] = '0;
    end
    m_ejf = 1'b1; e_ej_v = 0; e_ej_d = '0;
    for (int s = 0; s < 4; s++) begin
      best = -1;
      for (int i = 0; i < 4; i++)
        if (iv[i] != 0 && !done[i] && (best < 0 || ia[i] > ia[best])) best = i;
      if (best >= 0) begin
        done[best] = 1'b1;
        place(ix[best], iy[best], d);
        na = (ia[best] >= 15) ? 15 : ia[best] + 1;
        if (d == 4) begin e_ej_v = 1; e_ej_d = idat[best]; end
        else if (d >= 0) eo[d] = mk(1, ix[best], iy[best], na, idat[best]);
      end
    end
    e_rdy = (m_fr[0] | m_fr[1] | m_fr[2] | m_fr[3]) ? 1 : 0;
    if (jv != 0 && e_rdy != 0) begin
      place(jx, jy, d);
      if (d == 4) begin e_ej_v = 1; e_ej_d = jd; end
      else if (d >= 0) eo[d] = mk(1, jx, jy, 0, jd);
    end
  endtask

  task automatic clear_in();
    for (int i = 0; i < 4; i++) begin
      iv[i] = 0; ix[i] = 0; iy[i] = 0; ia[i] = 0; idat[i] = '0;
    end
    jv = 0; jx = 0; jy = 0; jd = '0;
  endtask

  task automatic set_in(int p, int x, int y, int a, logic [31:0] d);
    iv[p] = 1; ix[p] = x; iy[p] = y; ia[p] = a; idat[p] = d;
  endtask

  // called at a falling edge; returns at the falling edge after outputs settle
  task automatic step();
    my_x = 3'(mx); my_y = 3'(my);
    for (int i = 0; i < 4; i++) in_flit[i] = mk(iv[i], ix[i], iy[i], ia[i], idat[i]);
    inj_vld = 1'(jv); inj_dx = 3'(jx); inj_dy = 3'(jy); inj_data = jd;
    #1;
    model();
    chk("R7", "inj_ready", 64'(inj_ready), 64'(e_rdy));
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 4; p++)
      chk(has(p) ? "R5" : "R8", $sformatf("out port %0d", p), 64'(out_flit[p]), 64'(eo[p]));
    chk("R3", "eject", {31'd0, ej_vld, ej_data}, {31'd0, 1'(e_ej_v), e_ej_d});
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_1234);
    clear_in();
    mx = 3; my = 3;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 4; p++) chk("R1", "reset out", 64'(out_flit[p]), 64'd0);
    chk("R1", "reset eject", {63'd0, ej_vld}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R4: X first, eastward
    clear_in(); mx = 3; my = 3;
    set_in(3, 6, 1, 2, 32'hA5);
    step();
    chk("R4", "east route", 64'(out_flit[1]), 64'(mk(1, 6, 1, 3, 32'hA5)));
    // R4: X equal, northward
    clear_in(); set_in(2, 3, 6, 0, 32'hB6);
    step();
    chk("R4", "north route", 64'(out_flit[0]), 64'(mk(1, 3, 6, 1, 32'hB6)));
    // R5: older wins east, loser deflected to first free port (N)
    clear_in(); set_in(0, 6, 3, 5, 32'h11); set_in(2, 6, 3, 2, 32'h22);
    step();
    chk("R5", "older wins", 64'(out_flit[1]), 64'(mk(1, 6, 3, 6, 32'h11)));
    chk("R5", "loser deflected", 64'(out_flit[0]), 64'(mk(1, 6, 3, 3, 32'h22)));
    // R5: equal age, north input beats west input
    clear_in(); set_in(3, 5, 3, 1, 32'h33); set_in(0, 5, 3, 1, 32'h44);
    step();
    chk("R5", "tie order", 64'(out_flit[1]), 64'(mk(1, 5, 3, 2, 32'h44)));
    // R3: two local flits, east one ejected, west one deflected
    clear_in(); set_in(1, 3, 3, 0, 32'h55); set_in(3, 3, 3, 0, 32'h66);
    step();
    chk("R3", "eject one", {31'd0, ej_vld, ej_data}, {31'd0, 1'b1, 32'h55});
    chk("R3", "extra deflected", 64'(out_flit[0]), 64'(mk(1, 3, 3, 1, 32'h66)));
    // R7: four transit flits leave no room for injection
    clear_in();
    for (int i = 0; i < 4; i++) set_in(i, 0, 0, 1, 32'(i + 7));
    jv = 1; jx = 6; jy = 6; jd = 32'h77;
    step();
    chk("R7", "full no inject", {63'd0, 1'(e_rdy)}, 64'd0);
    // R6: age saturates
    clear_in(); set_in(1, 0, 3, 15, 32'h88);
    step();
    chk("R6", "age saturate", 64'(out_flit[3]), 64'(mk(1, 0, 3, 15, 32'h88)));
    // R9: injection to self ejects, injection westward leaves age 0
    clear_in(); jv = 1; jx = 3; jy = 3; jd = 32'h99;
    step();
    chk("R9", "inject eject", {31'd0, ej_vld, ej_data}, {31'd0, 1'b1, 32'h99});
    clear_in(); jv = 1; jx = 0; jy = 3; jd = 32'hAA;
    step();
    chk("R9", "inject west", 64'(out_flit[3]), 64'(mk(1, 0, 3, 0, 32'hAA)));
    // R8: corner node, both links used, injection refused
    clear_in(); mx = 0; my = 0;
    set_in(0, 5, 5, 0, 32'hC1); set_in(1, 5, 5, 0, 32'hC2);
    jv = 1; jx = 4; jy = 4; jd = 32'hC3;
    step();
    chk("R8", "corner ready", 64'(inj_ready), 64'd0);
    chk("R8", "corner N won E", 64'(out_flit[1]), 64'(mk(1, 5, 5, 1, 32'hC1)));
    chk("R8", "corner S silent", 64'(out_flit[2]), 64'd0);

    // R2: constrained random over corners, edges and interior
    for (int blk = 0; blk < 8; blk++) begin
      case (blk)
        0: begin mx = 0; my = 0; end
        1: begin mx = 7; my = 7; end
        2: begin mx = 0; my = 5; end
        3: begin mx = 7; my = 2; end
        4: begin mx = 3; my = 0; end
        5: begin mx = 4; my = 7; end
        6: begin mx = 3; my = 4; end
        default: begin mx = 5; my = 5; end
      endcase
      for (int c = 0; c < 400; c++) begin
        clear_in();
        for (int p = 0; p < 4; p++) begin
          if (has(p) && ($urandom % 10) < 6) begin
            set_in(p, ($urandom % 4 == 0) ? mx : int'($urandom % 8),
                   ($urandom % 4 == 0) ? my : int'($urandom % 8),
                   ($urandom % 8 == 0) ? 15 : int'($urandom % 4), $urandom);
          end
        end
        if ($urandom % 2 == 0) begin
          jv = 1; jx = $urandom % 8; jy = $urandom % 8; jd = $urandom;
        end
        step();
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule